// File: doc/BRIEF.md
# Master Clock Ratio Detector

This block runs on an audio master clock whose frequency is locked to the sample-rate frame clock, though the phase between them is arbitrary. It counts master clock cycles between successive rising edges of the frame clock and classifies each period as 256, 384 or 512 times the sample rate. No software setting is involved. Once two consecutive periods agree, it declares lock and reports the ratio.

While locked, it produces a base clock enable at 256 times the sample rate, whatever the master clock ratio is. A 512fs input gives a pulse every second cycle, a 384fs input gives pulses on two cycles of every three, and a 256fs input gives a pulse on every cycle. A second enable, at the modulator rate, is divided down from the base enable according to a two-bit oversampling mode. The block raises a configuration-error flag when the selected mode needs a faster master clock than the one detected. A power-down input holds every output inactive and clears the detection state, so the clocks may stop during power-down.

Top module: `master_ratio_detect`

## Requirements
- R1: A frame period counts as one ratio when it lies within ±2 master clock cycles of 256, 384 or 512 cycles. Any other period is out of range. The ratio code is 2'b01 for 256, 2'b10 for 384, 2'b11 for 512 and 2'b00 for none.
- R2: The first frame clock rising edge after reset or power-up only starts a count. `locked` rises a few cycles after the second of two consecutive measured periods with the same in-range class.
- R3: While locked, two consecutive measurements that are out of range or differ from the locked class clear `locked`. The ratio code then returns to 2'b00 and both enables stop. A single such measurement leaves lock intact.
- R4: While locked, `ratioCode` stays constant and is nonzero. While unlocked, it is 2'b00.
- R5: While locked, `baseEn` is high on every cycle for 256, on every second cycle for 512, and on two cycles of every three for 384. This gives exactly 256 pulses per frame period.
- R6: `modEn` marks every 4th, every 2nd or every `baseEn` pulse when `osMode` is 2'b00, 2'b01 or 2'b1x respectively. The low bit is ignored when the high bit is set. This gives 64, 128 or 256 pulses per frame, and `modEn` is never high without `baseEn`.
- R7: `cfgErr` is high exactly when the block is locked, `osMode[1]` is 1 and the detected ratio is not 512.
- R8: While `pwrUp` is low, all outputs are 0 and the detection state is cleared. After `pwrUp` returns high, lock again needs two fresh matching measurements.
- R9: If no frame clock rising edge arrives for 1024 cycles after a previous edge, that gap counts as one out-of-range measurement. A stopped frame clock therefore drops lock after two such gaps.
- R10: Detection does not depend on the frame clock's duty cycle or on its phase relative to the master clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pwrUp | input | 1 | 1 = operate, 0 = power-down |
| frameClk | input | 1 | Sample-rate frame clock, asynchronous in phase |
| osMode | input | 2 | Oversampling mode: 00 = 64fs, 01 = 128fs, 1x = 256fs |
| ratioCode | output | 2 | Detected ratio: 00 none, 01 256, 10 384, 11 512 |
| locked | output | 1 | Ratio detection locked |
| baseEn | output | 1 | Clock enable at 256fs |
| modEn | output | 1 | Modulator-rate clock enable |
| cfgErr | output | 1 | Mode needs 512fs but a different ratio is locked |

## Verification
The assertions assume the frame clock stays at each level for at least two master clock cycles, so the synchronizer sees every edge. Once the block is locked, they assume the ratio changes only through loss of lock or power-down. The stimulus meets these assumptions in three ways. Every frame's high time is drawn between an eighth and seven eighths of its period. Periods are jittered only within the ±2 window while a lock forms. A power-down pulse separates each random ratio choice from the next.

// File: rtl/ratio_pkg.sv
package ratio_pkg;

  typedef enum logic [1:0] {
    RATIO_NONE = 2'b00,
    RATIO_256  = 2'b01,
    RATIO_384  = 2'b10,
    RATIO_512  = 2'b11
  } ratio_e;

  // datapath -> control: one classified measurement
  typedef struct packed {
    logic   measValid;
    ratio_e measClass;
  } meas_t;

  // control -> datapath: strobes that run the enable generator
  typedef struct packed {
    logic   run;
    ratio_e activeRatio;
  } ctrl_strobe_t;

endpackage

// File: rtl/ratio_datapath.sv
module ratio_datapath
  import ratio_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int NOM_LO      = 256,
  parameter int NOM_MID     = 384,
  parameter int NOM_HI      = 512,
  parameter int TOL         = 2,
  parameter int TIMEOUT     = 1024
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clear,
  input  logic         frameClk,
  input  logic [1:0]   osMode,
  input  ctrl_strobe_t ctrl,
  output meas_t        meas,
  output logic         baseEn,
  output logic         modEn
);

  localparam int CNT_W = $clog2(TIMEOUT + 1);
  localparam int NUM_RATIOS = 3;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_TIMEOUT = CNT_W'(TIMEOUT);

  // frame clock synchronizer plus one history stage for edge detect
  logic [SYNC_STAGES:0] syncQ;
  logic frameRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else if (clear) syncQ <= '0;
    else syncQ <= {syncQ[SYNC_STAGES-1:0], frameClk};
  end

  assign frameRise = syncQ[SYNC_STAGES-1] & ~syncQ[SYNC_STAGES];

  // period counter
  logic [CNT_W-1:0] periodCnt;
  logic haveEdge;
  logic timeoutHit;

  assign timeoutHit = haveEdge && !frameRise && (periodCnt == CNT_TIMEOUT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodCnt <= '0;
      haveEdge  <= 1'b0;
    end else if (clear) begin
      periodCnt <= '0;
      haveEdge  <= 1'b0;
    end else if (frameRise) begin
      periodCnt <= CNT_ONE;
      haveEdge  <= 1'b1;
    end else if (timeoutHit) begin
      periodCnt <= CNT_ONE;
    end else if (haveEdge && periodCnt != CNT_TIMEOUT) begin
      periodCnt <= periodCnt + CNT_ONE;
    end
  end

  // window classifier, one comparator pair per supported ratio
  logic [NUM_RATIOS-1:0] winHit;

  for (genvar i = 0; i < NUM_RATIOS; i++) begin : g_window
    localparam int NOM = (i == 0) ? NOM_LO : (i == 1) ? NOM_MID : NOM_HI;
    localparam logic [CNT_W-1:0] WIN_LO = CNT_W'(NOM - TOL);
    localparam logic [CNT_W-1:0] WIN_HI = CNT_W'(NOM + TOL);
    assign winHit[i] = (periodCnt >= WIN_LO) && (periodCnt <= WIN_HI);
  end

  ratio_e periodClass;
  always_comb begin
    if (winHit[0])      periodClass = RATIO_256;
    else if (winHit[1]) periodClass = RATIO_384;
    else if (winHit[2]) periodClass = RATIO_512;
    else                periodClass = RATIO_NONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      meas <= '{measValid: 1'b0, measClass: RATIO_NONE};
    end else if (clear) begin
      meas <= '{measValid: 1'b0, measClass: RATIO_NONE};
    end else begin
      meas.measValid <= (frameRise && haveEdge) || timeoutHit;
      meas.measClass <= frameRise ? periodClass : RATIO_NONE;
    end
  end

  // 256fs base enable generator
  logic [1:0] basePhase;
  logic baseEnInt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) basePhase <= '0;
    else if (clear || !ctrl.run) basePhase <= '0;
    else begin
      case (ctrl.activeRatio)
        RATIO_384: basePhase <= (basePhase == 2'd2) ? 2'd0 : basePhase + 2'd1;
        RATIO_512: basePhase <= {1'b0, ~basePhase[0]};
        default:   basePhase <= 2'd0;
      endcase
    end
  end

  always_comb begin
    case (ctrl.activeRatio)
      RATIO_256: baseEnInt = ctrl.run;
      RATIO_384: baseEnInt = ctrl.run && (basePhase != 2'd2);
      RATIO_512: baseEnInt = ctrl.run && (basePhase == 2'd0);
      default:   baseEnInt = 1'b0;
    endcase
  end

  // modulator-rate divider: 4, 2 or 1 base pulses per output pulse
  logic [1:0] modPhase;
  logic [1:0] modMask;

  always_comb begin
    if (osMode[1])      modMask = 2'b00;
    else if (osMode[0]) modMask = 2'b01;
    else                modMask = 2'b11;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) modPhase <= '0;
    else if (clear || !ctrl.run) modPhase <= '0;
    else if (baseEnInt) modPhase <= modPhase + 2'd1;
  end

  assign baseEn = baseEnInt;
  assign modEn  = baseEnInt && ((modPhase & modMask) == 2'b00);

endmodule

// File: rtl/ratio_control.sv
module ratio_control
  import ratio_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         clear,
  input  meas_t        meas,
  output ctrl_strobe_t ctrl
);

  ratio_e candRatio;
  ratio_e lockedRatio;
  logic   lockedQ;
  logic   missOnce;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      candRatio   <= RATIO_NONE;
      lockedRatio <= RATIO_NONE;
      lockedQ     <= 1'b0;
      missOnce    <= 1'b0;
    end else if (clear) begin
      candRatio   <= RATIO_NONE;
      lockedRatio <= RATIO_NONE;
      lockedQ     <= 1'b0;
      missOnce    <= 1'b0;
    end else if (meas.measValid) begin
      if (!lockedQ) begin
        if (meas.measClass != RATIO_NONE && meas.measClass == candRatio) begin
          lockedQ     <= 1'b1;
          lockedRatio <= meas.measClass;
          missOnce    <= 1'b0;
        end
        candRatio <= meas.measClass;
      end else if (meas.measClass == lockedRatio) begin
        missOnce <= 1'b0;
      end else if (missOnce) begin
        lockedQ     <= 1'b0;
        lockedRatio <= RATIO_NONE;
        candRatio   <= RATIO_NONE;
        missOnce    <= 1'b0;
      end else begin
        missOnce <= 1'b1;
      end
    end
  end

  assign ctrl.run         = lockedQ;
  assign ctrl.activeRatio = lockedRatio;

endmodule

// File: rtl/master_ratio_detect.sv
module master_ratio_detect
  import ratio_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int NOM_LO      = 256,
  parameter int NOM_MID     = 384,
  parameter int NOM_HI      = 512,
  parameter int TOL         = 2,
  parameter int TIMEOUT     = 1024
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pwrUp,
  input  logic       frameClk,
  input  logic [1:0] osMode,
  output logic [1:0] ratioCode,
  output logic       locked,
  output logic       baseEn,
  output logic       modEn,
  output logic       cfgErr
);

  logic         clear;
  meas_t        meas;
  ctrl_strobe_t ctrl;
  logic         baseEnRaw;
  logic         modEnRaw;

  assign clear = !pwrUp;

  ratio_datapath #(
    .SYNC_STAGES(SYNC_STAGES), .NOM_LO(NOM_LO), .NOM_MID(NOM_MID),
    .NOM_HI(NOM_HI), .TOL(TOL), .TIMEOUT(TIMEOUT)
  ) datapath_i (
    .clk(clk), .rstN(rstN), .clear(clear), .frameClk(frameClk),
    .osMode(osMode), .ctrl(ctrl), .meas(meas),
    .baseEn(baseEnRaw), .modEn(modEnRaw)
  );

  ratio_control control_i (
    .clk(clk), .rstN(rstN), .clear(clear), .meas(meas), .ctrl(ctrl)
  );

  assign locked    = pwrUp && ctrl.run;
  assign ratioCode = locked ? ctrl.activeRatio : RATIO_NONE;
  assign baseEn    = pwrUp && baseEnRaw;
  assign modEn     = pwrUp && modEnRaw;
  assign cfgErr    = locked && osMode[1] && (ctrl.activeRatio != RATIO_512);

endmodule

// File: rtl/ratio_checker.sv
module ratio_checker (
  input logic       clk,
  input logic       rstN,
  input logic       pwrUp,
  input logic [1:0] osMode,
  input logic [1:0] ratioCode,
  input logic       locked,
  input logic       baseEn,
  input logic       modEn,
  input logic       cfgErr
);

  assert_code_when_locked_R4: assert property (@(posedge clk) disable iff (!rstN)
    locked |-> (ratioCode != 2'b00));

  assert_code_when_unlocked_R4: assert property (@(posedge clk) disable iff (!rstN)
    !locked |-> (ratioCode == 2'b00));

  assert_code_stable_R4: assert property (@(posedge clk) disable iff (!rstN)
    (locked && $past(locked)) |-> $stable(ratioCode));

  assert_every_cycle_R5: assert property (@(posedge clk) disable iff (!rstN)
    (locked && ratioCode == 2'b01) |-> baseEn);

  assert_half_rate_R5: assert property (@(posedge clk) disable iff (!rstN)
    (locked && ratioCode == 2'b11 && baseEn) |=> !baseEn);

  assert_two_of_three_R5: assert property (@(posedge clk) disable iff (!rstN)
    (locked && ratioCode == 2'b10 && !baseEn) |=> (baseEn || !locked));

  assert_no_enable_unlocked_R3: assert property (@(posedge clk) disable iff (!rstN)
    !locked |-> (!baseEn && !modEn));

  assert_mod_within_base_R6: assert property (@(posedge clk) disable iff (!rstN)
    modEn |-> baseEn);

  assert_full_rate_mod_R6: assert property (@(posedge clk) disable iff (!rstN)
    (osMode[1] && baseEn) |-> modEn);

  assert_cfg_err_R7: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |-> (locked && osMode[1] && ratioCode != 2'b11));

  assert_powerdown_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    !pwrUp |-> (!locked && !baseEn && !modEn && !cfgErr));

endmodule

bind master_ratio_detect ratio_checker checker_i (
  .clk(clk), .rstN(rstN), .pwrUp(pwrUp), .osMode(osMode),
  .ratioCode(ratioCode), .locked(locked), .baseEn(baseEn),
  .modEn(modEn), .cfgErr(cfgErr)
);

// File: tb/master_ratio_detect_tb.sv
module master_ratio_detect_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       pwrUp = 1'b0;
  logic       frameClk = 1'b0;
  logic [1:0] osMode = 2'b00;
  logic [1:0] ratioCode;
  logic       locked;
  logic       baseEn;
  logic       modEn;
  logic       cfgErr;

  int vecCount = 0;
  int errCount = 0;
  int baseCnt = 0;
  int modCnt = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  master_ratio_detect dut_i (
    .clk(clk), .rstN(rstN), .pwrUp(pwrUp), .frameClk(frameClk),
    .osMode(osMode), .ratioCode(ratioCode), .locked(locked),
    .baseEn(baseEn), .modEn(modEn), .cfgErr(cfgErr)
  );

  function automatic int expModCount(input logic [1:0] m);
    if (m[1]) return 256;
    if (m[0]) return 128;
    return 64;
  endfunction

  function automatic int expCfg(input int code, input logic [1:0] m);
    return (m[1] && code != 3) ? 1 : 0;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    vecCount++;
    if (act != exp) begin
      errCount++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one frame period: sample outputs then drive, both at the falling edge
  task automatic frame(input int p, input int hi);
    baseCnt = 0;
    modCnt = 0;
    for (int c = 0; c < p; c++) begin
      frameClk = (c < hi);
      @(negedge clk);
      baseCnt += int'(baseEn);
      modCnt += int'(modEn);
    end
    frameClk = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int c = 0; c < n; c++) @(negedge clk);
  endtask

  task automatic powerCycle();
    pwrUp = 1'b0;
    @(negedge clk);
    chk("R8 locked in power-down", int'(locked), 0);
    chk("R8 baseEn in power-down", int'(baseEn), 0);
    idle(3);
    pwrUp = 1'b1;
    idle(3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    idle(4);
    chk("R4 reset ratioCode", int'(ratioCode), 0);
    chk("R8 reset locked", int'(locked), 0);
    rstN = 1'b1;
    pwrUp = 1'b1;
    idle(3);

    // directed 384fs lock
    osMode = 2'b00;
    frame(384, 100);
    frame(384, 100);
    chk("R2 no lock after one measurement", int'(locked), 0);
    frame(384, 300);
    chk("R2 lock after two matching", int'(locked), 1);
    chk("R1 code for 384", int'(ratioCode), 2);
    frame(384, 192);
    chk("R5 base pulses at 384", baseCnt, 256);
    chk("R6 mod pulses mode 00", modCnt, 64);
    chk("R7 no error mode 00", int'(cfgErr), 0);
    osMode = 2'b01;
    frame(384, 50);
    chk("R6 mod pulses mode 01", modCnt, 128);
    osMode = 2'b10;
    frame(384, 50);
    chk("R7 error with 384 in 256x mode", int'(cfgErr), 1);
    chk("R6 mod pulses mode 10", modCnt, 256);

    // loss of lock by out-of-range periods
    osMode = 2'b00;
    frame(300, 100);
    frame(300, 100);
    chk("R3 lock held after one miss", int'(locked), 1);
    frame(300, 100);
    chk("R3 lock lost after two misses", int'(locked), 0);
    chk("R3 code cleared", int'(ratioCode), 0);
    frame(300, 100);
    chk("R3 no base pulses after loss", baseCnt, 0);

    // tolerance window
    powerCycle();
    for (int k = 0; k < 4; k++) frame(258, 20);
    chk("R1 258 accepted as 256", int'(ratioCode), 1);
    frame(256, 30);
    chk("R5 base pulses at 256", baseCnt, 256);
    frame(253, 30);
    frame(253, 30);
    chk("R1 253 first miss keeps lock", int'(locked), 1);
    frame(253, 30);
    chk("R1 253 rejected", int'(locked), 0);
    powerCycle();
    for (int k = 0; k < 4; k++) frame(514, 500);
    chk("R1 514 accepted as 512", int'(ratioCode), 3);

    // power-down clears lock; re-lock needs fresh measurements
    powerCycle();
    chk("R8 unlocked after power-up", int'(locked), 0);
    frame(512, 256);
    frame(512, 256);
    chk("R8 still unlocked after one measurement", int'(locked), 0);
    frame(512, 256);
    chk("R8 relock after power-up", int'(locked), 1);
    frame(512, 256);
    chk("R5 base pulses at 512", baseCnt, 256);

    // stopped frame clock
    idle(800);
    chk("R9 lock held after one gap", int'(locked), 1);
    idle(900);
    chk("R9 lock lost after stopped frame clock", int'(locked), 0);

    // random ratio, mode, duty and jitter
    for (int it = 0; it < 10; it++) begin
      int idx;
      int nom;
      int code;
      idx = int'($urandom_range(2, 0));
      nom = (idx == 0) ? 256 : (idx == 1) ? 384 : 512;
      code = idx + 1;
      osMode = 2'($urandom_range(3, 0));
      powerCycle();
      for (int k = 0; k < 3; k++)
        frame(nom + int'($urandom_range(4, 0)) - 2,
              int'($urandom_range(nom * 7 / 8, nom / 8)));
      frame(nom, int'($urandom_range(nom * 7 / 8, nom / 8)));
      chk("R10 lock with random duty", int'(locked), 1);
      chk("R1 random code", int'(ratioCode), code);
      frame(nom, int'($urandom_range(nom * 7 / 8, nom / 8)));
      chk("R5 random base pulses", baseCnt, 256);
      chk("R6 random mod pulses", modCnt, expModCount(osMode));
      chk("R7 random error flag", int'(cfgErr), expCfg(code, osMode));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
    $finish;
  end

endmodule